// File: doc/BRIEF.md
# Three-Wire Serial Flash Boot Loader

This controller pulls a boot image out of a serial NOR flash wired with only three pins: an active-low select, a serial clock, and one data line on which the flash input and output are tied together. The controller drives that shared line only while it shifts out opcode or address bits. At every other time it leaves the line to the flash.

Each boot starts with a recovery preamble, because the flash may have been left in dual or quad mode before the reset. The preamble is a one-byte all-ones exit, a sixteen-bit all-ones exit, and a two-opcode software reset. The controller then sends a wake-up opcode and polls the status register until the part is idle. Finally it issues a single read and delivers the requested number of bytes on a byte-wide output, each marked by a one-cycle strobe.

A status poll that stays busy for too many reads ends the boot with an error flag. A finished transfer raises a done flag. In both cases the select line is left high and the data line is released.

Top module: `spi_boot_reader`

## Requirements
- R1: While reset is held and after reset is released, with no start, csn_o is 1, sclk_o is 0, dq_oe_o is 0, and done_o, error_o and data_valid_o are 0.
- R2: After start_i, the first five select-low frames carry exactly these bits, in this order: 8 bits of 0xFF, 16 bits of 0xFFFF, 8 bits of 0x66, 8 bits of 0x99, and 8 bits of 0xAB. csn_o returns high between any two frames.
- R3: After the wake-up frame, the controller sends status frames. Each has 8 bits of 0x05 followed by one received byte. Status bit 0 set to 1 means busy. A busy reply leads to another status frame. The first reply with bit 0 clear leads on to the read.
- R4: When the number of busy status replies in one boot reaches poll_limit_i (a limit of 0 acts as 1), error_o is set and done_o stays 0. No read frame is sent, and csn_o ends high with dq_oe_o at 0.
- R5: The read is one frame. It carries the 8-bit opcode 0x03 and then the 24-bit start address (parameter START_ADDR, default 0). It then receives byte_count_i bytes, each assembled most significant bit first. Each byte appears on data_o with a single-cycle data_valid_o, and bytes come from consecutive addresses.
- R6: dq_oe_o is 1 only while csn_o is 0 and opcode or address bits are being shifted. It drops at the falling clock that follows the last such bit and is not raised again within that frame. It never overlaps the flash driving the line.
- R7: The link is SPI mode 0. sclk_o is low whenever csn_o is high, dq_o changes only while sclk_o is low, and dq_i is sampled as sclk_o rises.
- R8: While csn_o is low, every high phase and every low phase of sclk_o lasts exactly clk_div_i+1 clock cycles.
- R9: After the last byte is delivered, csn_o is high, dq_oe_o is 0, and done_o is 1. done_o holds until the next start_i, which clears done_o and error_o. A byte count of 0 sets done_o without any data_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a boot sequence (taken only when not running) |
| byte_count_i | input | CNT_W | Number of image bytes to read |
| clk_div_i | input | DIV_W | Serial half-period minus one, in clock cycles |
| poll_limit_i | input | POLL_W | Busy status replies tolerated before error |
| sclk_o | output | 1 | Serial clock to flash |
| csn_o | output | 1 | Active-low flash select |
| dq_o | output | 1 | Value driven onto the shared data line |
| dq_oe_o | output | 1 | Output enable for the shared data line |
| dq_i | input | 1 | Value read from the shared data line |
| data_o | output | 8 | Received image byte |
| data_valid_o | output | 1 | One-cycle strobe for data_o |
| done_o | output | 1 | Transfer finished |
| error_o | output | 1 | Busy poll limit exceeded |

## Verification
The assertions assume three things about the inputs. The flash drives dq_i only after the controller has let go of the line. start_i arrives only while the controller is idle or finished. clk_div_i, byte_count_i and poll_limit_i are held with start_i, since they are latched at that moment.

The stimulus stays inside these assumptions. A bench flash model drives the line only in its reply phase, changing it on falling clocks. Each boot is started only after the previous one has reported done or error. The random draws cover dividers 0 to 3, byte counts 1 to 40, and busy counts below the chosen limit. The directed cases add a zero byte count, a zero limit, and a busy count equal to the limit.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

   localparam logic [7:0] OP_EXIT   = 8'hFF;
   localparam logic [7:0] OP_RST_EN = 8'h66;
   localparam logic [7:0] OP_RST    = 8'h99;
   localparam logic [7:0] OP_WAKE   = 8'hAB;
   localparam logic [7:0] OP_STATUS = 8'h05;
   localparam logic [7:0] OP_READ   = 8'h03;

   localparam int TXW = 32;

   typedef enum logic [3:0] {
      SEQ_IDLE, SEQ_EXIT8, SEQ_EXIT16, SEQ_RST_EN, SEQ_RST,
      SEQ_WAKE, SEQ_STAT, SEQ_READ, SEQ_DONE, SEQ_FAIL
   } seq_state_e;

   typedef enum logic [1:0] {
      LNK_IDLE, LNK_TX, LNK_RX, LNK_GAP
   } link_state_e;

endpackage

// File: rtl/spi_boot_tick.sv
module spi_boot_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_boot_tick: DIV_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run_i)         cnt_q <= '0;
      else if (cnt_q == div_i) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = run_i && (cnt_q == div_i);

endmodule

// File: rtl/spi_boot_link.sv
module spi_boot_link
   import spi_boot_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [TXW-1:0]   tx_word_i,
   input  logic [5:0]       tx_bits_i,
   input  logic [CNT_W-1:0] rx_bytes_i,
   input  logic             tick_i,
   output logic             run_o,
   output logic             sclk_o,
   output logic             csn_o,
   output logic             dq_o,
   output logic             dq_oe_o,
   input  logic             dq_i,
   output logic [7:0]       rx_byte_o,
   output logic             rx_valid_o,
   output logic             fin_o
);

   localparam logic [CNT_W-1:0] ONE_B = 1;

   link_state_e      st_q;
   logic [TXW-1:0]   tx_sh_q;
   logic [5:0]       bits_left_q;
   logic [CNT_W-1:0] bytes_left_q;
   logic [7:0]       rx_sh_q;
   logic [2:0]       rx_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= LNK_IDLE;
         sclk_o       <= 1'b0;
         csn_o        <= 1'b1;
         dq_o         <= 1'b0;
         dq_oe_o      <= 1'b0;
         tx_sh_q      <= '0;
         bits_left_q  <= '0;
         bytes_left_q <= '0;
         rx_sh_q      <= '0;
         rx_cnt_q     <= '0;
         rx_byte_o    <= '0;
         rx_valid_o   <= 1'b0;
         fin_o        <= 1'b0;
      end else begin
         rx_valid_o <= 1'b0;
         fin_o      <= 1'b0;
         case (st_q)
            LNK_IDLE: begin
               if (go_i) begin
                  csn_o        <= 1'b0;
                  dq_oe_o      <= 1'b1;
                  dq_o         <= tx_word_i[TXW-1];
                  tx_sh_q      <= tx_word_i << 1;
                  bits_left_q  <= tx_bits_i;
                  bytes_left_q <= rx_bytes_i;
                  st_q         <= LNK_TX;
               end
            end
            LNK_TX: begin
               if (tick_i) begin
                  if (!sclk_o) begin
                     sclk_o      <= 1'b1;
                     bits_left_q <= bits_left_q - 6'd1;
                  end else begin
                     sclk_o <= 1'b0;
                     if (bits_left_q == 6'd0) begin
                        dq_oe_o <= 1'b0;
                        dq_o    <= 1'b0;
                        if (bytes_left_q == '0) begin
                           csn_o <= 1'b1;
                           st_q  <= LNK_GAP;
                        end else begin
                           rx_cnt_q <= '0;
                           st_q     <= LNK_RX;
                        end
                     end else begin
                        dq_o    <= tx_sh_q[TXW-1];
                        tx_sh_q <= tx_sh_q << 1;
                     end
                  end
               end
            end
            LNK_RX: begin
               if (tick_i) begin
                  if (!sclk_o) begin
                     sclk_o   <= 1'b1;
                     rx_sh_q  <= {rx_sh_q[6:0], dq_i};
                     rx_cnt_q <= rx_cnt_q + 3'd1;
                     if (rx_cnt_q == 3'd7) begin
                        rx_byte_o    <= {rx_sh_q[6:0], dq_i};
                        rx_valid_o   <= 1'b1;
                        bytes_left_q <= bytes_left_q - ONE_B;
                     end
                  end else begin
                     sclk_o <= 1'b0;
                     if (bytes_left_q == '0) begin
                        csn_o <= 1'b1;
                        st_q  <= LNK_GAP;
                     end
                  end
               end
            end
            default: begin
               if (tick_i) begin
                  st_q  <= LNK_IDLE;
                  fin_o <= 1'b1;
               end
            end
         endcase
      end
   end

   assign run_o = (st_q != LNK_IDLE);

endmodule

// File: rtl/spi_boot_reader.sv
module spi_boot_reader
   import spi_boot_pkg::*;
#(
   parameter int          CNT_W      = 16,
   parameter int          DIV_W      = 8,
   parameter int          POLL_W     = 16,
   parameter logic [23:0] START_ADDR = 24'h000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  byte_count_i,
   input  logic [DIV_W-1:0]  clk_div_i,
   input  logic [POLL_W-1:0] poll_limit_i,
   output logic              sclk_o,
   output logic              csn_o,
   output logic              dq_o,
   output logic              dq_oe_o,
   input  logic              dq_i,
   output logic [7:0]        data_o,
   output logic              data_valid_o,
   output logic              done_o,
   output logic              error_o
);

   generate
      if (CNT_W < 1 || POLL_W < 1) begin : g_bad_width
         $error("spi_boot_reader: CNT_W and POLL_W must be at least 1");
      end
   endgenerate

   seq_state_e        st_q;
   logic              go_q;
   logic [CNT_W-1:0]  count_q;
   logic [DIV_W-1:0]  div_q;
   logic [POLL_W-1:0] limit_q;
   logic [POLL_W-1:0] polls_q;
   logic [7:0]        stat_q;

   logic [TXW-1:0]    tx_word;
   logic [5:0]        tx_bits;
   logic [CNT_W-1:0]  rx_bytes;
   logic              run, tick, fin, rx_valid;
   logic [7:0]        rx_byte;
   logic              accept;
   logic              limit_hit;

   always_comb begin
      tx_word  = {OP_EXIT, 24'h0};
      tx_bits  = 6'd8;
      rx_bytes = '0;
      case (st_q)
         SEQ_EXIT16: begin tx_word = {OP_EXIT, OP_EXIT, 16'h0}; tx_bits = 6'd16; end
         SEQ_RST_EN: tx_word = {OP_RST_EN, 24'h0};
         SEQ_RST:    tx_word = {OP_RST, 24'h0};
         SEQ_WAKE:   tx_word = {OP_WAKE, 24'h0};
         SEQ_STAT: begin
            tx_word  = {OP_STATUS, 24'h0};
            rx_bytes = {{(CNT_W-1){1'b0}}, 1'b1};
         end
         SEQ_READ: begin
            tx_word  = {OP_READ, START_ADDR};
            tx_bits  = 6'd32;
            rx_bytes = count_q;
         end
         default: ;
      endcase
   end

   assign accept    = start_i && (st_q == SEQ_IDLE || st_q == SEQ_DONE || st_q == SEQ_FAIL);
   assign limit_hit = ({1'b0, polls_q} + 1'b1) >= {1'b0, limit_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         go_q    <= 1'b0;
         count_q <= '0;
         div_q   <= '0;
         limit_q <= '0;
         polls_q <= '0;
         stat_q  <= '0;
         done_o  <= 1'b0;
         error_o <= 1'b0;
      end else begin
         go_q <= 1'b0;
         if (rx_valid && st_q == SEQ_STAT) stat_q <= rx_byte;
         if (accept) begin
            done_o  <= 1'b0;
            error_o <= 1'b0;
            polls_q <= '0;
            count_q <= byte_count_i;
            div_q   <= clk_div_i;
            limit_q <= poll_limit_i;
            st_q    <= SEQ_EXIT8;
            go_q    <= 1'b1;
         end else if (fin) begin
            go_q <= 1'b1;
            case (st_q)
               SEQ_EXIT8:  st_q <= SEQ_EXIT16;
               SEQ_EXIT16: st_q <= SEQ_RST_EN;
               SEQ_RST_EN: st_q <= SEQ_RST;
               SEQ_RST:    st_q <= SEQ_WAKE;
               SEQ_WAKE:   st_q <= SEQ_STAT;
               SEQ_STAT: begin
                  if (!stat_q[0]) begin
                     st_q <= SEQ_READ;
                  end else if (limit_hit) begin
                     st_q    <= SEQ_FAIL;
                     error_o <= 1'b1;
                     go_q    <= 1'b0;
                  end else begin
                     polls_q <= polls_q + 1'b1;
                  end
               end
               default: begin
                  st_q   <= SEQ_DONE;
                  done_o <= 1'b1;
                  go_q   <= 1'b0;
               end
            endcase
         end
      end
   end

   spi_boot_tick #(.DIV_W(DIV_W)) i_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .div_i  (div_q),
      .tick_o (tick)
   );

   spi_boot_link #(.CNT_W(CNT_W)) i_link (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (go_q),
      .tx_word_i  (tx_word),
      .tx_bits_i  (tx_bits),
      .rx_bytes_i (rx_bytes),
      .tick_i     (tick),
      .run_o      (run),
      .sclk_o     (sclk_o),
      .csn_o      (csn_o),
      .dq_o       (dq_o),
      .dq_oe_o    (dq_oe_o),
      .dq_i       (dq_i),
      .rx_byte_o  (rx_byte),
      .rx_valid_o (rx_valid),
      .fin_o      (fin)
   );

   assign data_o       = rx_byte;
   assign data_valid_o = rx_valid && (st_q == SEQ_READ);

endmodule

// File: rtl/spi_boot_reader_chk.sv
module spi_boot_reader_chk (
   input logic clk,
   input logic rst_n,
   input logic sclk_o,
   input logic csn_o,
   input logic dq_o,
   input logic dq_oe_o,
   input logic data_valid_o,
   input logic done_o,
   input logic error_o
);

   // R6
   oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe_o |-> !csn_o);

   // R6
   oe_no_redrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!csn_o && $past(!csn_o) && !$past(dq_oe_o)) |-> !dq_oe_o);

   // R7
   clk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csn_o |-> !sclk_o);

   // R7
   data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(dq_o));

   // R2
   select_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csn_o) |=> csn_o);

   // R5
   valid_in_receive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_o |-> (!csn_o && !dq_oe_o));

   // R4
   done_error_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && error_o));

endmodule

bind spi_boot_reader spi_boot_reader_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sclk_o       (sclk_o),
   .csn_o        (csn_o),
   .dq_o         (dq_o),
   .dq_oe_o      (dq_oe_o),
   .data_valid_o (data_valid_o),
   .done_o       (done_o),
   .error_o      (error_o)
);

// File: tb/test_spi_boot_reader.sv
`timescale 1ns/1ps
module test_spi_boot_reader;

   localparam int CNT_W  = 16;
   localparam int DIV_W  = 8;
   localparam int POLL_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [CNT_W-1:0]  byte_count = '0;
   logic [DIV_W-1:0]  clk_div = '0;
   logic [POLL_W-1:0] poll_limit = '0;
   logic sclk, csn, dq_o, dq_oe, dq_i;
   logic [7:0] data;
   logic data_valid, done, error;

   int nchk = 0;
   int nfail = 0;

   // flash model state
   int  fl_bits;
   logic [31:0] fl_word;
   bit  fl_out;
   bit  fl_drv;
   bit  fl_bit;
   logic [7:0] fl_obyte;
   int  fl_obit;
   logic [23:0] fl_addr;
   int  busy_left;
   bit  oe_bad, clash, tim_bad, hold_bad;
   int  nfr;
   logic [31:0] fr_word [0:63];
   int  fr_bits [0:63];
   int  nbytes, nbad;
   int  cur_div;
   int  hi_run, lo_run;
   logic prev_sclk, prev_dq;

   always #5 clk = ~clk;

   assign dq_i = (fl_drv && !csn) ? fl_bit : 1'b1;

   spi_boot_reader #(.CNT_W(CNT_W), .DIV_W(DIV_W), .POLL_W(POLL_W)) i_spi_boot_reader (
      .clk(clk), .rst_n(rst_n), .start_i(start), .byte_count_i(byte_count),
      .clk_div_i(clk_div), .poll_limit_i(poll_limit), .sclk_o(sclk), .csn_o(csn),
      .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i), .data_o(data),
      .data_valid_o(data_valid), .done_o(done), .error_o(error));

   function automatic logic [7:0] mem_byte(input logic [23:0] a);
      return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // flash model: select falls -> new frame
   always @(negedge csn) begin
      fl_bits = 0; fl_word = '0; fl_out = 0; fl_drv <= 1'b0;
   end

   always @(posedge sclk) if (!csn) begin
      if (!fl_out) begin
         if (!dq_oe) oe_bad = 1;
         fl_word = {fl_word[30:0], dq_o};
         fl_bits++;
         if (fl_bits == 8 && fl_word[7:0] == 8'h05) begin
            fl_out = 1; fl_obit = 0;
            fl_obyte = (busy_left > 0) ? 8'h01 : 8'h00;
            if (busy_left > 0) busy_left--;
         end
         if (fl_bits == 32 && fl_word[31:24] == 8'h03) begin
            fl_out = 1; fl_obit = 0;
            fl_addr = fl_word[23:0];
            fl_obyte = mem_byte(fl_addr);
         end
      end else if (dq_oe) oe_bad = 1;
   end

   always @(negedge sclk) if (!csn && fl_out) begin
      fl_bit <= fl_obyte[7 - fl_obit];
      fl_drv <= 1'b1;
      if (fl_obit == 7) begin
         fl_obit = 0; fl_addr = fl_addr + 24'd1; fl_obyte = mem_byte(fl_addr);
      end else fl_obit++;
   end

   always @(posedge csn) if (nfr < 64 && rst_n) begin
      fr_word[nfr] = fl_word; fr_bits[nfr] = fl_bits; nfr++;
   end

   // port monitors, sampled away from the active edge
   always @(negedge clk) if (rst_n) begin
      if (dq_oe && fl_drv && !csn) clash = 1;
      if (sclk && prev_sclk && dq_o !== prev_dq) hold_bad = 1;
      if (!csn) begin
         if (sclk) begin
            if (!prev_sclk && lo_run != cur_div + 1) tim_bad = 1;
            hi_run++; lo_run = 0;
         end else begin
            if (prev_sclk && hi_run != cur_div + 1) tim_bad = 1;
            lo_run++; hi_run = 0;
         end
      end else begin
         hi_run = 0; lo_run = 0;
      end
      prev_sclk = sclk; prev_dq = dq_o;
      if (data_valid) begin
         if (data !== mem_byte(24'(nbytes))) nbad++;
         nbytes++;
      end
   end

   task automatic run_case(input int dv, input int cnt, input int busy, input int lim);
      int lim_eff, nstat, nexp;
      bit err_exp;
      bit timed_out;
      lim_eff = (lim == 0) ? 1 : lim;
      err_exp = (busy >= lim_eff);
      nstat   = err_exp ? lim_eff : busy + 1;
      nexp    = 5 + nstat + (err_exp ? 0 : 1);
      busy_left = busy; nfr = 0; nbytes = 0; nbad = 0;
      oe_bad = 0; clash = 0; tim_bad = 0; hold_bad = 0; cur_div = dv;
      @(negedge clk);
      clk_div = DIV_W'(dv); byte_count = CNT_W'(cnt); poll_limit = POLL_W'(lim);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      // R9 start clears the flags
      chk(!done && !error, "R9", "flags cleared by start", int'(done) + int'(error), 0);
      timed_out = 1;
      for (int i = 0; i < 20000; i++) begin
         if (done || error) begin timed_out = 0; break; end
         @(negedge clk);
      end
      chk(!timed_out, "R9", "completion", int'(timed_out), 0);
      repeat (3 * (dv + 1) + 4) @(negedge clk);
      chk(nfr == nexp, "R3", "frame count", nfr, nexp);
      if (nfr >= 5) begin
         chk(fr_bits[0] == 8  && fr_word[0][7:0]  == 8'hFF,    "R2", "exit8",  int'(fr_word[0][15:0]), 'hFF);
         chk(fr_bits[1] == 16 && fr_word[1][15:0] == 16'hFFFF, "R2", "exit16", int'(fr_word[1][15:0]), 'hFFFF);
         chk(fr_bits[2] == 8  && fr_word[2][7:0]  == 8'h66,    "R2", "reset enable", int'(fr_word[2][7:0]), 'h66);
         chk(fr_bits[3] == 8  && fr_word[3][7:0]  == 8'h99,    "R2", "reset", int'(fr_word[3][7:0]), 'h99);
         chk(fr_bits[4] == 8  && fr_word[4][7:0]  == 8'hAB,    "R2", "wake", int'(fr_word[4][7:0]), 'hAB);
      end
      for (int k = 5; k < 5 + nstat && k < nfr; k++)
         chk(fr_bits[k] == 8 && fr_word[k][7:0] == 8'h05, "R3", "status opcode", int'(fr_word[k][7:0]), 'h05);
      if (!err_exp && nfr == nexp)
         chk(fr_bits[nexp-1] == 32 && fr_word[nexp-1] == 32'h03000000, "R5", "read command",
             int'(fr_word[nexp-1]), 'h03000000);
      chk(error == err_exp, "R4", "error flag", int'(error), int'(err_exp));
      chk(done == !err_exp, "R9", "done flag", int'(done), int'(!err_exp));
      chk(nbytes == (err_exp ? 0 : cnt), "R5", "byte count", nbytes, err_exp ? 0 : cnt);
      chk(nbad == 0, "R5", "data mismatches", nbad, 0);
      chk(!oe_bad && !clash, "R6", "drive window", int'(oe_bad) * 2 + int'(clash), 0);
      chk(!hold_bad, "R7", "data change while clock high", int'(hold_bad), 0);
      chk(!tim_bad, "R8", "clock phase length", int'(tim_bad), 0);
      chk(csn && !dq_oe && !sclk, "R9", "pins released", int'(csn) * 4 + int'(dq_oe) * 2 + int'(sclk), 4);
      repeat (10) @(negedge clk);
      chk(done == !err_exp, "R9", "flag held", int'(done), int'(!err_exp));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nfail++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      prev_sclk = 0; prev_dq = 0; hi_run = 0; lo_run = 0; nfr = 0; fl_drv = 0; fl_bit = 0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(csn === 1'b1 && sclk === 1'b0 && dq_oe === 1'b0, "R1", "pins in reset",
          int'(csn) * 4 + int'(sclk) * 2 + int'(dq_oe), 4);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(csn && !sclk && !dq_oe, "R1", "idle pins", int'(csn) * 4 + int'(sclk) * 2 + int'(dq_oe), 4);
      chk(!done && !error && !data_valid, "R1", "idle flags",
          int'(done) + int'(error) + int'(data_valid), 0);
      // directed corners
      run_case(0, 4, 0, 3);
      run_case(1, 3, 3, 10);
      run_case(0, 2, 5, 5);   // R4 limit reached
      run_case(2, 0, 0, 1);   // R9 zero count
      run_case(0, 1, 2, 0);   // R4 zero limit acts as one
      for (int n = 0; n < 6; n++) begin
         int dv, cnt, busy, lim;
         dv   = int'($urandom % 4);
         cnt  = 1 + int'($urandom % 40);
         busy = int'($urandom % 4);
         lim  = busy + 1 + int'($urandom % 3);
         run_case(dv, cnt, busy, lim);
      end
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule